// File: doc/BRIEF.md
# Receive Packet Framer with Address and CRC Filtering

This block takes the serial bit stream of a demodulator and turns it into stored frame bytes for a receive FIFO. Bits arrive most significant first, each one marked by a bit-valid strobe. The block looks for a sync word of one to four bytes. Once the sync word matches, it assembles the bytes that follow and frames them by either a fixed length or a length byte carried in the frame. It can drop frames whose address byte does not match the node address, and it can check a CRC-16 that trails the frame.

The FIFO itself is outside this block, which drives only its write strobe, write data and synchronous clear. The clear empties the whole FIFO. The preamble, the sync word and the CRC bytes are never stored; only the length, address and payload bytes are written. A one-cycle `payload_ready` pulse marks the completion of a frame. `crc_ok` holds the verdict of the most recent frame that completed. All configuration arrives on static input ports.

Top module: `rx_pkt_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fifo_we`, `fifo_clr`, `payload_ready` and `crc_ok` are low.
- R2: The sync word is the low `cfg_sync_len+1` bytes of `cfg_sync_word`, with its most significant byte received first. Only cycles with `bit_valid` high deliver bits. A match needs that many sync bits received while searching, and none of those bits is written to the FIFO.
- R3: In fixed mode (`cfg_var_len`=0), exactly `cfg_payload_len` bytes after the sync word are stored. A configured length of zero discards the frame.
- R4: In variable mode, the first byte after sync is the length. It is stored and is followed by that many bytes, all of which are stored. A length of zero, or one greater than `cfg_payload_len`, drops the frame with nothing written and no pulse.
- R5: With `cfg_addr_en` set, the address byte is the first byte after sync in fixed mode and the second in variable mode. On a mismatch nothing more is written and no ready pulse follows. `fifo_clr` pulses only if the length byte was already written.
- R6: With `cfg_crc_en` set, a CRC-16 follows the frame, high byte first. It uses polynomial 0x1021, a preset of 0xFFFF and an inverted result, and it covers the stored bytes. When the CRC matches, `payload_ready` pulses for one cycle, in the cycle after the final CRC bit, and `crc_ok` becomes 1.
- R7: When the CRC mismatches and `cfg_crc_keep` is 0, `fifo_clr` pulses instead of `payload_ready`, and `crc_ok` becomes 0.
- R8: When the CRC mismatches and `cfg_crc_keep` is 1, the bytes stay in the FIFO, `payload_ready` pulses, and `crc_ok` becomes 0.
- R9: With `cfg_crc_en` clear, `payload_ready` pulses in the cycle after the last bit of the last stored byte, and `crc_ok` becomes 0.
- R10: Each stored byte produces one `fifo_we` cycle in the cycle after its last bit. `fifo_we` and `fifo_clr` are never high together, and `crc_ok` changes only together with a `payload_ready` or `fifo_clr` pulse.
- R11: After any frame ends, the block searches for sync again, and a match needs a full fresh sync word of bits received after that end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe for `bit_in` |
| bit_in | input | 1 | Demodulated bit, MSB first |
| cfg_sync_len | input | 2 | Sync word length in bytes minus one |
| cfg_sync_word | input | 32 | Sync pattern, low bytes used |
| cfg_var_len | input | 1 | 1 = length byte framing, 0 = fixed |
| cfg_payload_len | input | 8 | Fixed length, or maximum accepted length |
| cfg_addr_en | input | 1 | Enable address filtering |
| cfg_node_addr | input | 8 | Node address to match |
| cfg_crc_en | input | 1 | Enable CRC check |
| cfg_crc_keep | input | 1 | Keep data and signal ready on CRC failure |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| fifo_clr | output | 1 | FIFO synchronous clear |
| payload_ready | output | 1 | One-cycle frame-complete pulse |
| crc_ok | output | 1 | CRC verdict of the last completed frame |

## Verification
The bench covers the following failure modes:
- A length limit applied with the wrong comparison would let an oversized length byte through, so extra bytes would appear in the FIFO.
- Fixing the address position to one place breaks one of the two framing modes. The bench therefore checks the address filter in both modes, including whether a clear follows when a length byte has already been written.
- A CRC failure is tested with the keep setting both off and on. A design that ignored the setting would either lose the stored bytes or raise a ready pulse that should not appear.
- Stale payload bits are left in the sync shifter right after a frame, arranged so that a design which does not require a fresh sync word would lock onto a false frame.

// File: rtl/rx_pkt_framer.sv
module rx_pkt_framer #(
  parameter int SYNC_BYTES = 4,
  parameter int LEN_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_valid,
  input  logic                  bit_in,
  input  logic [1:0]            cfg_sync_len,
  input  logic [SYNC_BYTES*8-1:0] cfg_sync_word,
  input  logic                  cfg_var_len,
  input  logic [LEN_W-1:0]      cfg_payload_len,
  input  logic                  cfg_addr_en,
  input  logic [7:0]            cfg_node_addr,
  input  logic                  cfg_crc_en,
  input  logic                  cfg_crc_keep,
  output logic                  fifo_we,
  output logic [7:0]            fifo_wdata,
  output logic                  fifo_clr,
  output logic                  payload_ready,
  output logic                  crc_ok
);
  localparam int SYNC_W = SYNC_BYTES * 8;
  localparam int CNT_W  = $clog2(SYNC_W + 1);

  typedef enum logic [2:0] {S_SYNC, S_LEN, S_BODY, S_CRC_HI, S_CRC_LO} state_t;

  state_t            state;
  logic [SYNC_W-1:0] sync_sh, sync_mask;
  logic [CNT_W-1:0]  sync_cnt;
  logic [2:0]        bit_cnt;
  logic [7:0]        byte_sh, crc_hi;
  logic [LEN_W-1:0]  remain;
  logic              first_body, written;
  logic [15:0]       crc;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  always_comb
    for (int i = 0; i < SYNC_W; i++)
      sync_mask[i] = (i < (int'(cfg_sync_len) + 1) * 8);

  wire [SYNC_W-1:0] sync_nx  = {sync_sh[SYNC_W-2:0], bit_in};
  wire [CNT_W-1:0]  cnt_nx   = (int'(sync_cnt) >= SYNC_W) ? sync_cnt : sync_cnt + 1'b1;
  wire              sync_hit = (((sync_nx ^ cfg_sync_word) & sync_mask) == '0) &&
                               (int'(cnt_nx) >= (int'(cfg_sync_len) + 1) * 8);
  wire [7:0]        rx_byte  = {byte_sh[6:0], bit_in};
  wire              byte_done = bit_valid && (state != S_SYNC) && (bit_cnt == 3'd7);
  wire              addr_bad = first_body && cfg_addr_en && (rx_byte != cfg_node_addr);
  wire              crc_good = ({crc_hi, rx_byte} == ~crc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_SYNC;
      sync_sh       <= '0;
      sync_cnt      <= '0;
      bit_cnt       <= '0;
      byte_sh       <= '0;
      crc_hi        <= '0;
      remain        <= '0;
      first_body    <= 1'b0;
      written       <= 1'b0;
      crc           <= 16'hFFFF;
      fifo_we       <= 1'b0;
      fifo_wdata    <= '0;
      fifo_clr      <= 1'b0;
      payload_ready <= 1'b0;
      crc_ok        <= 1'b0;
    end else begin
      fifo_we       <= 1'b0;
      fifo_clr      <= 1'b0;
      payload_ready <= 1'b0;
      if (state == S_SYNC) begin
        if (bit_valid) begin
          sync_sh  <= sync_nx;
          sync_cnt <= cnt_nx;
          if (sync_hit) begin
            sync_cnt   <= '0;
            bit_cnt    <= '0;
            crc        <= 16'hFFFF;
            first_body <= 1'b1;
            written    <= 1'b0;
            remain     <= cfg_payload_len;
            if (cfg_var_len)             state <= S_LEN;
            else if (cfg_payload_len != '0) state <= S_BODY;
          end
        end
      end else if (bit_valid) begin
        bit_cnt <= bit_cnt + 3'd1;
        byte_sh <= rx_byte;
        if (byte_done) begin
          case (state)
            S_LEN: begin
              if (rx_byte == 8'd0 || LEN_W'(rx_byte) > cfg_payload_len) begin
                state <= S_SYNC;
              end else begin
                fifo_we    <= 1'b1;
                fifo_wdata <= rx_byte;
                crc        <= crc_step(crc, rx_byte);
                remain     <= LEN_W'(rx_byte);
                written    <= 1'b1;
                state      <= S_BODY;
              end
            end
            S_BODY: begin
              if (addr_bad) begin
                fifo_clr <= written;
                state    <= S_SYNC;
              end else begin
                fifo_we    <= 1'b1;
                fifo_wdata <= rx_byte;
                crc        <= crc_step(crc, rx_byte);
                first_body <= 1'b0;
                written    <= 1'b1;
                remain     <= remain - 1'b1;
                if (remain == LEN_W'(1)) begin
                  if (cfg_crc_en) begin
                    state <= S_CRC_HI;
                  end else begin
                    payload_ready <= 1'b1;
                    crc_ok        <= 1'b0;
                    state         <= S_SYNC;
                  end
                end
              end
            end
            S_CRC_HI: begin
              crc_hi <= rx_byte;
              state  <= S_CRC_LO;
            end
            S_CRC_LO: begin
              crc_ok <= crc_good;
              if (crc_good || cfg_crc_keep) payload_ready <= 1'b1;
              else                          fifo_clr      <= 1'b1;
              state <= S_SYNC;
            end
            default: state <= S_SYNC;
          endcase
        end
      end
    end
  end
endmodule

module rx_pkt_framer_chk #(
  parameter int LEN_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic fifo_we,
  input logic fifo_clr,
  input logic payload_ready,
  input logic crc_ok
);
  int unsigned wr_since;

  always_ff @(posedge clk) begin
    if (!rst_n)                         wr_since <= 0;
    else if (payload_ready || fifo_clr) wr_since <= 0;
    else if (fifo_we)                   wr_since <= wr_since + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !(fifo_we || fifo_clr || payload_ready || crc_ok));
  p_we_after_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(bit_valid));
  p_we_clr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_we && fifo_clr));
  p_ready_not_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(payload_ready && fifo_clr));
  p_ready_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    payload_ready |-> $past(bit_valid));
  p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    payload_ready |=> !payload_ready);
  p_crc_ok_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_ok) |-> (payload_ready || fifo_clr));
  p_frame_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_since <= (2 ** LEN_W));
endmodule

bind rx_pkt_framer rx_pkt_framer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .fifo_we(fifo_we),
  .fifo_clr(fifo_clr), .payload_ready(payload_ready), .crc_ok(crc_ok)
);

// File: tb/rx_pkt_framer_bench.sv
module rx_pkt_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0, bit_in = 1'b0;
  logic [1:0]  cfg_sync_len = 2'd1;
  logic [31:0] cfg_sync_word = 32'h0000D391;
  logic        cfg_var_len = 1'b0;
  logic [7:0]  cfg_payload_len = 8'd4;
  logic        cfg_addr_en = 1'b0;
  logic [7:0]  cfg_node_addr = 8'h00;
  logic        cfg_crc_en = 1'b0, cfg_crc_keep = 1'b0;
  logic        fifo_we, fifo_clr, payload_ready, crc_ok;
  logic [7:0]  fifo_wdata;

  rx_pkt_framer u_rx_pkt_framer (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .cfg_sync_len(cfg_sync_len), .cfg_sync_word(cfg_sync_word),
    .cfg_var_len(cfg_var_len), .cfg_payload_len(cfg_payload_len),
    .cfg_addr_en(cfg_addr_en), .cfg_node_addr(cfg_node_addr),
    .cfg_crc_en(cfg_crc_en), .cfg_crc_keep(cfg_crc_keep),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .fifo_clr(fifo_clr),
    .payload_ready(payload_ready), .crc_ok(crc_ok)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int mcount = 0, nready = 0, nclr = 0;
  logic [7:0] mfifo [0:299];
  logic [7:0] tx_q[$];
  logic [7:0] exp_q[$];
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (fifo_clr) begin mcount = 0; nclr++; end
    if (fifo_we) begin mfifo[mcount] = fifo_wdata; mcount++; end
    if (payload_ready) nready++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k]) begin
      c = c ^ {q[k], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return ~c;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mcount = 0; nready = 0; nclr = 0;
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap);
    for (int i = 7; i >= 0; i--) begin
      bit_valid = 1'b1; bit_in = v[i];
      @(negedge clk);
      bit_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic send_sync(input int gap);
    for (int i = int'(cfg_sync_len); i >= 0; i--) send_byte(cfg_sync_word[8*i +: 8], gap);
  endtask

  // preamble, sync, tx_q, optional CRC; bad flips a CRC bit
  task automatic send_pkt(input bit with_crc, input bit bad, input int gap);
    logic [15:0] c;
    send_byte(8'hAA, gap); send_byte(8'hAA, gap);
    send_sync(gap);
    foreach (tx_q[k]) send_byte(tx_q[k], gap);
    if (with_crc) begin
      c = ref_crc(tx_q) ^ (bad ? 16'h0040 : 16'h0000);
      send_byte(c[15:8], gap); send_byte(c[7:0], gap);
    end
  endtask

  task automatic expect_fifo(input string req);
    check(mcount == exp_q.size(), req, mcount, exp_q.size());
    foreach (exp_q[k]) if (k < mcount)
      check(mfifo[k] == exp_q[k], req, mfifo[k], exp_q[k]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_valid = 1'b0;
    repeat (2) @(negedge clk);
    check({fifo_we, fifo_clr, payload_ready, crc_ok} == 4'b0, "R1", {fifo_we, fifo_clr, payload_ready, crc_ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({fifo_we, fifo_clr, payload_ready, crc_ok} == 4'b0, "R1", {fifo_we, fifo_clr, payload_ready, crc_ok}, 0);
  endtask

  task automatic t_fixed_plain();
    do_reset();
    cfg_sync_len = 2'd1; cfg_sync_word = 32'h0000D391; cfg_var_len = 0;
    cfg_payload_len = 8'd4; cfg_addr_en = 0; cfg_crc_en = 0;
    tx_q = '{8'h11, 8'h22, 8'h33, 8'h44};
    send_pkt(0, 0, 1);
    repeat (3) @(negedge clk);
    exp_q = tx_q;
    expect_fifo("R3");
    check(nready == 1, "R9", nready, 1);
    check(crc_ok == 0, "R9", crc_ok, 0);
  endtask

  task automatic t_var_crc_pass();
    do_reset();
    cfg_sync_len = 2'd3; cfg_sync_word = 32'h12345678; cfg_var_len = 1;
    cfg_payload_len = 8'd10; cfg_addr_en = 1; cfg_node_addr = 8'h5A;
    cfg_crc_en = 1; cfg_crc_keep = 0;
    tx_q = '{8'h04, 8'h5A, 8'h01, 8'h02, 8'h03};
    send_pkt(1, 0, 0);
    check(payload_ready == 1, "R6", payload_ready, 1);
    repeat (3) @(negedge clk);
    exp_q = tx_q;
    expect_fifo("R4");
    check(nready == 1, "R6", nready, 1);
    check(crc_ok == 1, "R6", crc_ok, 1);
  endtask

  task automatic t_var_oversize();
    do_reset();
    cfg_sync_len = 2'd3; cfg_sync_word = 32'h12345678; cfg_var_len = 1;
    cfg_payload_len = 8'd3; cfg_addr_en = 0; cfg_crc_en = 0;
    tx_q = '{8'h04, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
    send_pkt(0, 0, 0);
    repeat (3) @(negedge clk);
    check(mcount == 0, "R4", mcount, 0);
    check(nready == 0, "R4", nready, 0);
    tx_q = '{8'h03, 8'hB1, 8'hB2, 8'hB3};
    send_pkt(0, 0, 0);
    repeat (3) @(negedge clk);
    exp_q = tx_q;
    expect_fifo("R11");
    check(nready == 1, "R11", nready, 1);
  endtask

  task automatic t_addr_var();
    do_reset();
    cfg_sync_len = 2'd3; cfg_sync_word = 32'h12345678; cfg_var_len = 1;
    cfg_payload_len = 8'd8; cfg_addr_en = 1; cfg_node_addr = 8'h5A; cfg_crc_en = 0;
    tx_q = '{8'h03, 8'h66, 8'h07, 8'h08};
    send_pkt(0, 0, 0);
    repeat (3) @(negedge clk);
    check(mcount == 0, "R5", mcount, 0);
    check(nclr == 1, "R5", nclr, 1);
    check(nready == 0, "R5", nready, 0);
  endtask

  task automatic t_addr_fixed();
    do_reset();
    cfg_sync_len = 2'd0; cfg_sync_word = 32'h000000C5; cfg_var_len = 0;
    cfg_payload_len = 8'd3; cfg_addr_en = 1; cfg_node_addr = 8'h21; cfg_crc_en = 0;
    tx_q = '{8'h21, 8'h0E, 8'h0F};
    send_pkt(0, 0, 0);
    repeat (3) @(negedge clk);
    exp_q = tx_q;
    expect_fifo("R5");
    tx_q = '{8'h22, 8'h0E, 8'h0F};
    send_pkt(0, 0, 0);
    repeat (3) @(negedge clk);
    expect_fifo("R5");
    check(nclr == 0, "R5", nclr, 0);
    check(nready == 1, "R5", nready, 1);
  endtask

  task automatic t_crc_fail(input bit keep);
    do_reset();
    cfg_sync_len = 2'd1; cfg_sync_word = 32'h0000D391; cfg_var_len = 1;
    cfg_payload_len = 8'd8; cfg_addr_en = 0; cfg_crc_en = 1; cfg_crc_keep = keep;
    tx_q = '{8'h02, 8'h31, 8'h32};
    send_pkt(1, 0, 0);
    repeat (2) @(negedge clk);
    check(crc_ok == 1, keep ? "R8" : "R7", crc_ok, 1);
    tx_q = '{8'h02, 8'h41, 8'h42};
    send_pkt(1, 1, 0);
    repeat (3) @(negedge clk);
    check(crc_ok == 0, keep ? "R8" : "R7", crc_ok, 0);
    if (keep) begin
      exp_q = '{8'h02, 8'h31, 8'h32, 8'h02, 8'h41, 8'h42};
      expect_fifo("R8");
      check(nready == 2, "R8", nready, 2);
    end else begin
      check(mcount == 0, "R7", mcount, 0);
      check(nready == 1, "R7", nready, 1);
      check(nclr == 1, "R7", nclr, 1);
    end
  endtask

  task automatic t_fresh_sync();
    do_reset();
    cfg_sync_len = 2'd1; cfg_sync_word = 32'h0000D391; cfg_var_len = 0;
    cfg_payload_len = 8'd2; cfg_addr_en = 0; cfg_crc_en = 0;
    tx_q = '{8'h55, 8'hD3};
    send_pkt(0, 0, 0);
    send_byte(8'h91, 0);
    send_byte(8'h77, 0); send_byte(8'h78, 0);
    repeat (3) @(negedge clk);
    exp_q = '{8'h55, 8'hD3};
    expect_fifo("R11");
    check(nready == 1, "R11", nready, 1);
    send_sync(0);
    send_byte(8'h9A, 0); send_byte(8'h9B, 0);
    repeat (3) @(negedge clk);
    exp_q = '{8'h55, 8'hD3, 8'h9A, 8'h9B};
    expect_fifo("R2");
  endtask

  initial begin
    t_reset();
    t_fixed_plain();
    t_var_crc_pass();
    t_var_oversize();
    t_addr_var();
    t_addr_fixed();
    t_crc_fail(0);
    t_crc_fail(1);
    t_fresh_sync();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule